// File: doc/BRIEF.md
# Speculative Poison-Bit Register File

This block is a general-purpose register file in which every entry carries one extra poison bit. The poison bit lets the core hoist loads and other faulting instructions above branches. When an instruction flagged as speculative hits a fatal fault, such as a protection violation, it does not trap. It marks its destination as poisoned, and the fault stays latent until the program really needs the value.

The pipeline presents one result per cycle on the write port. With each result it gives the speculative flag, whether the result faulted, whether the fault is fatal, and whether any source operand was already poisoned. From these the block decides what happens. The result may be stored, the destination may be poisoned, a trap may be raised at once, or the write may be dropped. The read ports return each value together with its poison bit. They raise a deferred trap when a non-speculative consumer touches a poisoned register.

A check port sits at the original program position of the hoisted instruction. It tests one register and, if that register is poisoned, asks for recovery and reports the register index. It never traps. Reads and checks see a write in the same cycle (write-first). Register 0 is hardwired to zero.

Top module: `spec_poison_regfile`

## Requirements
- R1: After reset every register reads zero with its poison bit clear.
- R2: Register 0 always reads zero with poison clear. A write addressed to it changes nothing, but its exception outputs still follow R6 and R7.
- R3: A write with wr_fault_i=0 and wr_src_nat_i=0 stores wr_data_i and clears the poison bit. The value is visible from the next cycle onward.
- R4: When a committing write and a read or check name the same register in the same cycle, the read returns the newly committed value and poison bit.
- R5: A write with wr_spec_i=1, wr_fault_i=1 and wr_fatal_i=1 sets the destination's poison bit and data to zero, and it asserts neither exc_fatal_o nor exc_resume_o. A fault takes precedence over wr_src_nat_i.
- R6: A write with wr_spec_i=0, wr_fault_i=1 and wr_fatal_i=1 asserts exc_fatal_o in the same cycle and leaves the register file unchanged.
- R7: A write with wr_fault_i=1 and wr_fatal_i=0 asserts exc_resume_o in the same cycle, whatever the value of wr_spec_i, and leaves the register file unchanged.
- R8: A speculative, non-faulting write with wr_src_nat_i=1 poisons its destination (data zero) and raises no exception.
- R9: A non-speculative, non-faulting write with wr_src_nat_i=1 leaves the register file unchanged and raises no exception on the write side.
- R10: defer_trap_o[p] is 1 exactly when read port p is enabled (rd_en_i[p]=1), is non-speculative (rd_spec_i[p]=0) and returns a poisoned register. Speculative or disabled reads still return the poison bit on rd_nat_o[p].
- R11: With chk_en_i=1 on a poisoned register, recover_req_o=1 and recover_idx_o=chk_addr_i. Otherwise recover_req_o=0 and recover_idx_o=0, and the check leaves the register file unchanged.
- R12: The read ports work independently, each with its own address, enable and speculative flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Result present on the write port |
| wr_addr_i | input | 5 | Destination register |
| wr_data_i | input | 32 | Result value |
| wr_spec_i | input | 1 | Producing instruction is speculative |
| wr_fault_i | input | 1 | Producing instruction faulted |
| wr_fatal_i | input | 1 | Fault class: 1 fatal, 0 resumable |
| wr_src_nat_i | input | 1 | A source operand was poisoned |
| rd_en_i | input | 2 | Per-port read enable |
| rd_spec_i | input | 2 | Per-port speculative consumer flag |
| rd_addr_i | input | 2x5 | Per-port register index |
| rd_data_o | output | 2x32 | Per-port read value |
| rd_nat_o | output | 2 | Per-port poison bit |
| defer_trap_o | output | 2 | Per-port deferred fault trap |
| exc_fatal_o | output | 1 | Immediate fatal trap from the write port |
| exc_resume_o | output | 1 | Immediate resumable trap from the write port |
| chk_en_i | input | 1 | Check instruction present |
| chk_addr_i | input | 5 | Register tested by the check |
| recover_req_o | output | 1 | Recovery request |
| recover_idx_o | output | 5 | Register needing recovery, zero when idle |

## Verification
The hardest situation to reach is a poisoned register that is touched in the same cycle by a new write, by a non-speculative read and by a check. Here the bypass, the trap decision and the poison-clearing rules all act at once. Uniform random traffic over 32 registers seldom lines these up. The random stimulus therefore draws every address from a window of eight registers that includes register 0, and it raises the fault rate to about one write in four. Poisoned entries build up and then get read, checked and overwritten in the same cycles. Directed steps add the single-case sequences first.

// File: rtl/spr_pkg.sv
package spr_pkg;

   // What the write port does with the register file this cycle
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_WRITE  = 2'd1,
      ACT_POISON = 2'd2,
      ACT_DROP   = 2'd3
   } wr_act_e;

   // Immediate exception raised by the write port
   typedef enum logic [1:0] {
      EXC_NONE   = 2'd0,
      EXC_FATAL  = 2'd1,
      EXC_RESUME = 2'd2
   } exc_e;

endpackage

// File: rtl/spr_fault_policy.sv
module spr_fault_policy
   import spr_pkg::*;
(
   input  logic    en_i,
   input  logic    spec_i,
   input  logic    fault_i,
   input  logic    fatal_i,
   input  logic    src_nat_i,
   output wr_act_e act_o,
   output exc_e    exc_o
);

   always_comb begin
      act_o = ACT_NONE;
      exc_o = EXC_NONE;
      if (en_i) begin
         if (fault_i && !fatal_i) begin
            // resumable: service now, instruction will replay
            act_o = ACT_DROP;
            exc_o = EXC_RESUME;
         end else if (fault_i && spec_i) begin
            // fatal but speculative: defer through poison
            act_o = ACT_POISON;
         end else if (fault_i) begin
            act_o = ACT_DROP;
            exc_o = EXC_FATAL;
         end else if (src_nat_i && spec_i) begin
            act_o = ACT_POISON;
         end else if (src_nat_i) begin
            // consumer read already raised the deferred trap
            act_o = ACT_DROP;
         end else begin
            act_o = ACT_WRITE;
         end
      end
   end

endmodule

// File: rtl/spr_store.sv
module spr_store #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 32,
   parameter bit ZERO_REG = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cm_en_i,
   input  logic [ADDR_W-1:0] cm_addr_i,
   input  logic [DATA_W-1:0] cm_data_i,
   input  logic              cm_nat_i,
   output logic [DATA_W-1:0] arr_data_o [NUM_REGS],
   output logic              arr_nat_o  [NUM_REGS]
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (ZERO_REG && g == 0) begin : g_hard
         assign arr_data_o[g] = '0;
         assign arr_nat_o[g]  = 1'b0;
      end else begin : g_flop
         logic              sel;
         logic [DATA_W-1:0] data_q;
         logic              nat_q;

         assign sel = cm_en_i && (cm_addr_i == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               nat_q  <= 1'b0;
            end else if (sel) begin
               data_q <= cm_data_i;
               nat_q  <= cm_nat_i;
            end
         end

         assign arr_data_o[g] = data_q;
         assign arr_nat_o[g]  = nat_q;
      end
   end

endmodule

// File: rtl/spr_view.sv
module spr_view #(
   parameter int NUM_REGS    = 32,
   parameter int DATA_W      = 32,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] arr_data_i [NUM_REGS],
   input  logic              arr_nat_i  [NUM_REGS],
   input  logic              cm_en_i,
   input  logic [ADDR_W-1:0] cm_addr_i,
   input  logic [DATA_W-1:0] cm_data_i,
   input  logic              cm_nat_i,
   output logic [DATA_W-1:0] data_o,
   output logic              nat_o
);

   logic [DATA_W-1:0] raw_data;
   logic              raw_nat;

   assign raw_data = arr_data_i[addr_i];
   assign raw_nat  = arr_nat_i[addr_i];

   if (WRITE_FIRST) begin : g_bypass
      logic hit;
      assign hit    = cm_en_i && (cm_addr_i == addr_i);
      assign data_o = hit ? cm_data_i : raw_data;
      assign nat_o  = hit ? cm_nat_i  : raw_nat;
   end else begin : g_plain
      logic unused_cm;
      assign unused_cm = cm_en_i ^ (^cm_addr_i) ^ (^cm_data_i) ^ cm_nat_i;
      assign data_o    = raw_data;
      assign nat_o     = raw_nat;
   end

endmodule

// File: rtl/spec_poison_regfile.sv
module spec_poison_regfile
   import spr_pkg::*;
#(
   parameter int NUM_REGS    = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_RD      = 2,
   parameter bit ZERO_REG    = 1'b1,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic                           wr_spec_i,
   input  logic                           wr_fault_i,
   input  logic                           wr_fatal_i,
   input  logic                           wr_src_nat_i,
   input  logic [NUM_RD-1:0]              rd_en_i,
   input  logic [NUM_RD-1:0]              rd_spec_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
   output logic [NUM_RD-1:0]              rd_nat_o,
   output logic [NUM_RD-1:0]              defer_trap_o,
   output logic                           exc_fatal_o,
   output logic                           exc_resume_o,
   input  logic                           chk_en_i,
   input  logic [ADDR_W-1:0]              chk_addr_i,
   output logic                           recover_req_o,
   output logic [ADDR_W-1:0]              recover_idx_o
);

   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_regs
      $error("spec_poison_regfile: NUM_REGS must be a power of two >= 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("spec_poison_regfile: DATA_W must be >= 1");
   end
   if (NUM_RD < 1) begin : g_bad_ports
      $error("spec_poison_regfile: NUM_RD must be >= 1");
   end

   wr_act_e           act;
   exc_e              exc;
   logic              cm_en;
   logic [DATA_W-1:0] cm_data;
   logic              cm_nat;
   logic [DATA_W-1:0] arr_data [NUM_REGS];
   logic              arr_nat  [NUM_REGS];

   spr_fault_policy u_policy (
      .en_i      (wr_en_i),
      .spec_i    (wr_spec_i),
      .fault_i   (wr_fault_i),
      .fatal_i   (wr_fatal_i),
      .src_nat_i (wr_src_nat_i),
      .act_o     (act),
      .exc_o     (exc)
   );

   // commit stage: target register 0 is inert when hardwired
   logic addr_live;
   if (ZERO_REG) begin : g_zero_gate
      assign addr_live = (wr_addr_i != '0);
   end else begin : g_no_gate
      assign addr_live = 1'b1;
   end

   assign cm_en   = addr_live && (act == ACT_WRITE || act == ACT_POISON);
   assign cm_nat  = (act == ACT_POISON);
   assign cm_data = cm_nat ? '0 : wr_data_i;

   assign exc_fatal_o  = (exc == EXC_FATAL);
   assign exc_resume_o = (exc == EXC_RESUME);

   spr_store #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ZERO_REG (ZERO_REG)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cm_en_i    (cm_en),
      .cm_addr_i  (wr_addr_i),
      .cm_data_i  (cm_data),
      .cm_nat_i   (cm_nat),
      .arr_data_o (arr_data),
      .arr_nat_o  (arr_nat)
   );

   // read ports
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [DATA_W-1:0] v_data;
      logic              v_nat;

      spr_view #(
         .NUM_REGS    (NUM_REGS),
         .DATA_W      (DATA_W),
         .WRITE_FIRST (WRITE_FIRST)
      ) u_view (
         .addr_i     (rd_addr_i[p]),
         .arr_data_i (arr_data),
         .arr_nat_i  (arr_nat),
         .cm_en_i    (cm_en),
         .cm_addr_i  (wr_addr_i),
         .cm_data_i  (cm_data),
         .cm_nat_i   (cm_nat),
         .data_o     (v_data),
         .nat_o      (v_nat)
      );

      assign rd_data_o[p]    = v_data;
      assign rd_nat_o[p]     = v_nat;
      assign defer_trap_o[p] = rd_en_i[p] && !rd_spec_i[p] && v_nat;
   end

   // check port shares the read view, data path unused
   logic [DATA_W-1:0] chk_data;
   logic              chk_nat;
   logic              unused_chk_data;

   spr_view #(
      .NUM_REGS    (NUM_REGS),
      .DATA_W      (DATA_W),
      .WRITE_FIRST (WRITE_FIRST)
   ) u_chk_view (
      .addr_i     (chk_addr_i),
      .arr_data_i (arr_data),
      .arr_nat_i  (arr_nat),
      .cm_en_i    (cm_en),
      .cm_addr_i  (wr_addr_i),
      .cm_data_i  (cm_data),
      .cm_nat_i   (cm_nat),
      .data_o     (chk_data),
      .nat_o      (chk_nat)
   );

   assign unused_chk_data = ^chk_data;
   assign recover_req_o   = chk_en_i && chk_nat;
   assign recover_idx_o   = recover_req_o ? chk_addr_i : '0;

endmodule

// File: rtl/spr_chk.sv
module spr_chk #(
   parameter int NUM_REGS    = 32,
   parameter int DATA_W      = 32,
   parameter int NUM_RD      = 2,
   parameter bit ZERO_REG    = 1'b1,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en_i,
   input logic [ADDR_W-1:0]             wr_addr_i,
   input logic [DATA_W-1:0]             wr_data_i,
   input logic                          wr_spec_i,
   input logic                          wr_fault_i,
   input logic                          wr_fatal_i,
   input logic                          wr_src_nat_i,
   input logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_i,
   input logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o,
   input logic [NUM_RD-1:0]             rd_nat_o,
   input logic                          exc_fatal_o,
   input logic                          exc_resume_o,
   input logic                          chk_en_i,
   input logic                          recover_req_o,
   input logic [ADDR_W-1:0]             recover_idx_o
);

   // R6
   fatal_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_fault_i && wr_fatal_i && !wr_spec_i) |-> exc_fatal_o);

   // R5
   spec_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_fault_i && wr_fatal_i && wr_spec_i) |-> (!exc_fatal_o && !exc_resume_o));

   // R7
   resume_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_fault_i && !wr_fatal_i) |-> (exc_resume_o && !exc_fatal_o));

   // R11
   idle_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en_i |-> (!recover_req_o && recover_idx_o == '0));

   if (WRITE_FIRST) begin : g_bypass_chk
      // R4
      bypass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && !wr_fault_i && !wr_src_nat_i && wr_addr_i != '0 && rd_addr_i[0] == wr_addr_i)
         |-> (rd_data_o[0] == wr_data_i && !rd_nat_o[0]));

      // R5
      bypass_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && wr_fault_i && wr_fatal_i && wr_spec_i && wr_addr_i != '0 && rd_addr_i[0] == wr_addr_i)
         |-> (rd_nat_o[0] && rd_data_o[0] == '0));
   end

   if (ZERO_REG) begin : g_zero_chk
      for (genvar p = 0; p < NUM_RD; p++) begin : g_port
         // R2
         zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr_i[p] == '0) |-> (rd_data_o[p] == '0 && !rd_nat_o[p]));
      end
   end

endmodule

bind spec_poison_regfile spr_chk #(
   .NUM_REGS    (NUM_REGS),
   .DATA_W      (DATA_W),
   .NUM_RD      (NUM_RD),
   .ZERO_REG    (ZERO_REG),
   .WRITE_FIRST (WRITE_FIRST)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en_i       (wr_en_i),
   .wr_addr_i     (wr_addr_i),
   .wr_data_i     (wr_data_i),
   .wr_spec_i     (wr_spec_i),
   .wr_fault_i    (wr_fault_i),
   .wr_fatal_i    (wr_fatal_i),
   .wr_src_nat_i  (wr_src_nat_i),
   .rd_addr_i     (rd_addr_i),
   .rd_data_o     (rd_data_o),
   .rd_nat_o      (rd_nat_o),
   .exc_fatal_o   (exc_fatal_o),
   .exc_resume_o  (exc_resume_o),
   .chk_en_i      (chk_en_i),
   .recover_req_o (recover_req_o),
   .recover_idx_o (recover_idx_o)
);

// File: tb/spec_poison_regfile_tb_top.sv
module spec_poison_regfile_tb_top;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [4:0]       wr_addr = '0;
   logic [31:0]      wr_data = '0;
   logic             wr_spec = 1'b0;
   logic             wr_fault = 1'b0;
   logic             wr_fatal = 1'b0;
   logic             wr_src_nat = 1'b0;
   logic [1:0]       rd_en = '0;
   logic [1:0]       rd_spec = '0;
   logic [1:0][4:0]  rd_addr = '0;
   logic [1:0][31:0] rd_data;
   logic [1:0]       rd_nat;
   logic [1:0]       defer_trap;
   logic             exc_fatal;
   logic             exc_resume;
   logic             chk_en = 1'b0;
   logic [4:0]       chk_addr = '0;
   logic             recover_req;
   logic [4:0]       recover_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] m_data [32];
   logic        m_nat  [32];

   always #2 clk = ~clk;

   spec_poison_regfile dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (wr_en),
      .wr_addr_i     (wr_addr),
      .wr_data_i     (wr_data),
      .wr_spec_i     (wr_spec),
      .wr_fault_i    (wr_fault),
      .wr_fatal_i    (wr_fatal),
      .wr_src_nat_i  (wr_src_nat),
      .rd_en_i       (rd_en),
      .rd_spec_i     (rd_spec),
      .rd_addr_i     (rd_addr),
      .rd_data_o     (rd_data),
      .rd_nat_o      (rd_nat),
      .defer_trap_o  (defer_trap),
      .exc_fatal_o   (exc_fatal),
      .exc_resume_o  (exc_resume),
      .chk_en_i      (chk_en),
      .chk_addr_i    (chk_addr),
      .recover_req_o (recover_req),
      .recover_idx_o (recover_idx)
   );

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // 0 none, 1 store, 2 poison, 3 drop
   function automatic int exp_act(input logic we, spec, fault, fatal, srcnat);
      if (!we) return 0;
      if (fault && !fatal) return 3;
      if (fault && spec) return 2;
      if (fault) return 3;
      if (srcnat && spec) return 2;
      if (srcnat) return 3;
      return 1;
   endfunction

   function automatic string scen_tag(input logic we, spec, fault, fatal, srcnat,
                                      input logic [4:0] wa);
      if (!we) return "R12";
      if (fault && !fatal) return "R7";
      if (fault && spec) return "R5";
      if (fault) return "R6";
      if (srcnat && spec) return "R8";
      if (srcnat) return "R9";
      if (wa == 0) return "R2";
      return "R3";
   endfunction

   task automatic step(input string tag,
                       input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic spec, input logic fault, input logic fatal, input logic srcnat,
                       input logic [4:0] ra0, input logic re0, input logic rs0,
                       input logic [4:0] ra1, input logic re1, input logic rs1,
                       input logic ce, input logic [4:0] ca);
      int a;
      logic cm;
      logic [31:0] cdat;
      logic cnat;
      logic [4:0] ras [2];
      logic res [2];
      logic rss [2];
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; wr_spec = spec;
      wr_fault = fault; wr_fatal = fatal; wr_src_nat = srcnat;
      rd_addr[0] = ra0; rd_en[0] = re0; rd_spec[0] = rs0;
      rd_addr[1] = ra1; rd_en[1] = re1; rd_spec[1] = rs1;
      chk_en = ce; chk_addr = ca;
      #1;
      a    = exp_act(we, spec, fault, fatal, srcnat);
      cm   = (a == 1 || a == 2) && wa != 0;
      cnat = (a == 2);
      cdat = cnat ? 32'h0 : wd;
      ras[0] = ra0; ras[1] = ra1; res[0] = re0; res[1] = re1; rss[0] = rs0; rss[1] = rs1;
      for (int p = 0; p < 2; p++) begin
         logic [31:0] ed;
         logic en;
         if (ras[p] == 0) begin ed = 0; en = 0; end
         else if (cm && ras[p] == wa) begin ed = cdat; en = cnat; end
         else begin ed = m_data[ras[p]]; en = m_nat[ras[p]]; end
         cmp(tag, $sformatf("rd%0d data (R4,R12)", p), rd_data[p], ed);
         cmp(tag, $sformatf("rd%0d poison (R10)", p), {31'b0, rd_nat[p]}, {31'b0, en});
         cmp(tag, $sformatf("rd%0d trap (R10)", p), {31'b0, defer_trap[p]},
             {31'b0, res[p] && !rss[p] && en});
      end
      cmp(tag, "exc_fatal (R6)", {31'b0, exc_fatal}, {31'b0, we && fault && fatal && !spec});
      cmp(tag, "exc_resume (R7)", {31'b0, exc_resume}, {31'b0, we && fault && !fatal});
      begin
         logic cn;
         if (ca == 0) cn = 0;
         else if (cm && ca == wa) cn = cnat;
         else cn = m_nat[ca];
         cmp(tag, "recover_req (R11)", {31'b0, recover_req}, {31'b0, ce && cn});
         cmp(tag, "recover_idx (R11)", {27'b0, recover_idx}, {27'b0, (ce && cn) ? ca : 5'd0});
      end
      if (cm) begin
         m_data[wa] = cdat;
         m_nat[wa]  = cnat;
      end
   endtask

   // read-only step on two ports plus check
   task automatic peek(input string tag, input logic [4:0] r0, input logic [4:0] r1,
                       input logic rs, input logic ce, input logic [4:0] ca);
      step(tag, 0, 0, 0, 0, 0, 0, 0, r0, 1, rs, r1, 1, rs, ce, ca);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 32; i++) begin m_data[i] = 0; m_nat[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state on every register
      for (int i = 0; i < 32; i += 2) peek("R1", 5'(i), 5'(i + 1), 0, 0, 0);

      // R3 plain store then read next cycle
      step("R3", 1, 5, 32'ha5a5_1234, 0, 0, 0, 0, 1, 1, 0, 2, 1, 0, 0, 0);
      peek("R3", 5, 5, 0, 1, 5);
      // R4 same-cycle bypass on both ports and check
      step("R4", 1, 6, 32'hdead_beef, 0, 0, 0, 0, 6, 1, 0, 6, 1, 0, 1, 6);
      // R2 write to register 0 discarded
      step("R2", 1, 0, 32'hffff_ffff, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0);
      peek("R2", 0, 6, 0, 0, 0);
      step("R2", 1, 0, 32'h1, 0, 1, 1, 0, 0, 1, 0, 0, 1, 0, 0, 0);
      // R5 speculative fatal fault poisons, seen via bypass
      step("R5", 1, 7, 32'h1111_2222, 1, 1, 1, 0, 7, 1, 1, 7, 1, 0, 0, 0);
      // R10 non-speculative read traps, speculative read does not
      peek("R10", 7, 7, 0, 0, 0);
      peek("R10", 7, 5, 1, 0, 0);
      step("R10", 0, 0, 0, 0, 0, 0, 0, 7, 0, 0, 7, 0, 1, 0, 0);
      // R11 check on poisoned and on clean register
      peek("R11", 5, 7, 1, 1, 7);
      peek("R11", 5, 7, 1, 1, 5);
      peek("R11", 5, 7, 1, 0, 7);
      // R8 speculative poison propagation
      step("R8", 1, 8, 32'h7777_0000, 1, 0, 0, 1, 8, 1, 1, 5, 1, 0, 0, 0);
      peek("R8", 8, 8, 0, 1, 8);
      // R9 non-speculative write with poisoned source is dropped
      step("R9", 1, 5, 32'h0bad_0bad, 0, 0, 0, 1, 5, 1, 0, 9, 1, 0, 0, 0);
      peek("R9", 5, 5, 0, 0, 0);
      // R6 non-speculative fatal traps, register kept
      step("R6", 1, 5, 32'h6666_6666, 0, 1, 1, 0, 5, 1, 0, 5, 1, 0, 0, 0);
      peek("R6", 5, 5, 0, 0, 0);
      // R7 resumable fault, both speculative and not
      step("R7", 1, 5, 32'h7070_7070, 1, 1, 0, 0, 5, 1, 0, 5, 1, 0, 0, 0);
      step("R7", 1, 5, 32'h7171_7171, 0, 1, 0, 1, 5, 1, 0, 5, 1, 0, 0, 0);
      peek("R7", 5, 5, 0, 0, 0);
      // R3 normal write clears poison
      step("R3", 1, 7, 32'hc1ea_0007, 0, 0, 0, 0, 7, 1, 0, 8, 1, 0, 1, 7);
      peek("R3", 7, 8, 0, 1, 7);

      // constrained random traffic over a small window
      for (int n = 0; n < 4000; n++) begin
         logic we, sp, fa, ft, sn;
         logic [4:0] wa;
         we = ($urandom_range(0, 3) != 0);
         wa = 5'($urandom_range(0, 7));
         sp = $urandom_range(0, 1) == 1;
         fa = ($urandom_range(0, 3) == 0);
         ft = $urandom_range(0, 1) == 1;
         sn = ($urandom_range(0, 4) == 0);
         step(scen_tag(we, sp, fa, ft, sn, wa), we, wa, $urandom, sp, fa, ft, sn,
              5'($urandom_range(0, 7)), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              5'($urandom_range(0, 7)), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, 5'($urandom_range(0, 7)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule